// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows the state of one DRAM bank as a DDR2-style controller or memory model drives it. It watches the Activate, Read and Write strobes together with the column bit that asks for auto-precharge. From these it works out the clock edge at which the bank's internal precharge begins, and it reports when a fresh Activate may be issued to the bank.

The precharge start is not a fixed offset from the command. For a Read it is the latest of three points: the nominal burst end, the read-to-precharge limit measured from the last 4-bit prefetch, and the active-time minimum measured from the Activate. For a Write it is the later of write recovery after the burst and the same active-time minimum. The next Activate then needs two conditions at once: the precharge time counted from the start that may have moved, and the row cycle time counted from the previous Activate.

All timing values are static integer clock counts. The burst length is 4 or 8. A command that breaks the rules is flagged and otherwise ignored.

Top module: `bank_apre_tracker`

## Requirements
- R1: While `rst_n` is sampled low, and after it, the outputs are `open_o`=0, `act_ok_o`=1, `pre_start_o`=0 and `viol_o`=0.
- R2: An Activate sampled at an edge while `act_ok_o` is 1 opens the bank. From that edge on, `open_o`=1 and `act_ok_o`=0.
- R3: A Read or Write sampled with `ap_i`=0 on an open bank leaves `open_o` at 1 and raises no `pre_start_o` and no `viol_o`.
- R4: A Read with `ap_i`=1 sampled at edge n on an open bank gives a one-cycle `pre_start_o` pulse that begins at edge n+D. With H = 2 when `cfg_bl8_i`=0 and H = 4 when `cfg_bl8_i`=1, D = max(AL+H, AL+H-2+tRTP, tRAS-g), where g is the number of edges from the Activate to the command.
- R5: When tRAS-g is the largest term, the pulse is pushed out to exactly edge Activate+tRAS.
- R6: When the term AL+H-2+tRTP is the largest, the pulse is pushed out to that edge.
- R7: A Write with `ap_i`=1 uses D = max(AL+(CL-1)+H+tWR, tRAS-g).
- R8: With precharge start at edge P and Activate at edge A, `act_ok_o` is 1 just before edge m only if m >= P+tRP and m >= A+tRC. It first rises just before edge max(P+tRP, A+tRC).
- R9: `open_o` stays 1 until edge P and falls at the same edge where `pre_start_o` rises.
- R10: An Activate sampled while `act_ok_o`=0 makes `viol_o`=1 for the next cycle and changes neither `open_o` nor the timers.
- R11: A Read or Write sampled while the bank is closed, armed for auto-precharge or precharging makes `viol_o`=1 for the next cycle and is ignored.
- R12: When two or more of `act_i`, `rd_i` and `wr_i` are sampled high together, `viol_o`=1 for the next cycle and all of them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| act_i | input | 1 | Activate strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ap_i | input | 1 | Auto-precharge request sampled with Read or Write |
| cfg_bl8_i | input | 1 | Burst length: 0 = BL4, 1 = BL8 |
| cfg_al_i | input | TW | Additive latency in cycles |
| cfg_cl_i | input | TW | CAS latency in cycles; write latency is CL-1 |
| cfg_twr_i | input | TW | Write recovery in cycles |
| cfg_trtp_i | input | TW | Read-to-precharge in cycles |
| cfg_tras_i | input | TW | Minimum Activate-to-precharge in cycles |
| cfg_trp_i | input | TW | Precharge period in cycles |
| cfg_trc_i | input | TW | Activate-to-Activate in cycles |
| open_o | output | 1 | Bank open and not yet precharging |
| pre_start_o | output | 1 | One-cycle pulse at the internal precharge start |
| act_ok_o | output | 1 | An Activate at the next edge would be legal |
| viol_o | output | 1 | The command at the previous edge broke a rule and was ignored |

## Verification
A wrong stored delay or a mis-loaded timer shows at the ports as a `pre_start_o` pulse one or more cycles away from the edge that the formula gives. It also shifts the rise of `act_ok_o`. Both appear within the same command sequence, a few tens of cycles at most. The bench therefore measures both edges exactly for reads and writes of both burst lengths, with each term of the maximum made the winner in turn. A state machine that accepts an illegal command shows up on the next cycle as a missing `viol_o` or a changed `open_o`.

// File: rtl/apre_pkg.sv
package apre_pkg;
   typedef enum logic [1:0] {
      BK_IDLE  = 2'd0,
      BK_OPEN  = 2'd1,
      BK_ARMED = 2'd2,
      BK_PRECH = 2'd3
   } bank_st_e;

   // timer slots
   localparam int TMR_RAS  = 0;
   localparam int TMR_RC   = 1;
   localparam int TMR_RP   = 2;
   localparam int TMR_WAIT = 3;
   localparam int TMR_NUM  = 4;
endpackage

// File: rtl/apre_timer.sv
module apre_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic [CW-1:0] cnt_o,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

   assign cnt_o  = cnt_q;
   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/apre_delay_calc.sv
module apre_delay_calc #(
   parameter int CW = 9
) (
   input  logic          is_wr_i,
   input  logic          bl8_i,
   input  logic [CW-1:0] al_i,
   input  logic [CW-1:0] cl_i,
   input  logic [CW-1:0] twr_i,
   input  logic [CW-1:0] trtp_i,
   input  logic [CW-1:0] ras_rem_i,
   output logic [CW-1:0] dly_o
);
   logic [CW-1:0] half, cwl, rd_nom, rd_rtp, rd_end, wr_end, base;

   always_comb begin
      half   = bl8_i ? CW'(4) : CW'(2);
      cwl    = (cl_i == '0) ? '0 : cl_i - CW'(1);
      rd_nom = al_i + half;
      // tRTP runs from the last 4-bit prefetch
      rd_rtp = al_i + (half - CW'(2)) + trtp_i;
      rd_end = (rd_rtp > rd_nom) ? rd_rtp : rd_nom;
      wr_end = al_i + cwl + half + twr_i;
      base   = is_wr_i ? wr_end : rd_end;
      dly_o  = (ras_rem_i > base) ? ras_rem_i : base;
   end
endmodule

// File: rtl/bank_apre_tracker.sv
module bank_apre_tracker #(
   parameter int TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_i,
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic          ap_i,
   input  logic          cfg_bl8_i,
   input  logic [TW-1:0] cfg_al_i,
   input  logic [TW-1:0] cfg_cl_i,
   input  logic [TW-1:0] cfg_twr_i,
   input  logic [TW-1:0] cfg_trtp_i,
   input  logic [TW-1:0] cfg_tras_i,
   input  logic [TW-1:0] cfg_trp_i,
   input  logic [TW-1:0] cfg_trc_i,
   output logic          open_o,
   output logic          pre_start_o,
   output logic          act_ok_o,
   output logic          viol_o
);
   import apre_pkg::*;

   localparam int CW = TW + 3;

   generate
      if (TW < 3) begin : g_bad_tw
         $error("bank_apre_tracker: TW must be at least 3");
      end
   endgenerate

   function automatic logic [CW-1:0] less1(input logic [TW-1:0] v);
      return (v == '0) ? '0 : CW'(v) - CW'(1);
   endfunction

   bank_st_e st_q, st_d;
   logic pre_q, viol_q;
   logic multi, rw_any, act_acc, rw_acc, ap_acc, bad, fire;
   logic [CW-1:0] dly;

   logic          tmr_ld   [TMR_NUM];
   logic [CW-1:0] tmr_val  [TMR_NUM];
   logic [CW-1:0] tmr_cnt  [TMR_NUM];
   logic          tmr_done [TMR_NUM];

   genvar g;
   generate
      for (g = 0; g < TMR_NUM; g++) begin : g_tmr
         apre_timer #(.CW(CW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (tmr_ld[g]),
            .val_i  (tmr_val[g]),
            .cnt_o  (tmr_cnt[g]),
            .done_o (tmr_done[g])
         );
      end
   endgenerate

   apre_delay_calc #(.CW(CW)) u_calc (
      .is_wr_i   (wr_i),
      .bl8_i     (cfg_bl8_i),
      .al_i      (CW'(cfg_al_i)),
      .cl_i      (CW'(cfg_cl_i)),
      .twr_i     (CW'(cfg_twr_i)),
      .trtp_i    (CW'(cfg_trtp_i)),
      .ras_rem_i (tmr_cnt[TMR_RAS]),
      .dly_o     (dly)
   );

   // command decode
   always_comb begin
      multi    = ($countones({act_i, rd_i, wr_i}) > 1);
      rw_any   = (rd_i | wr_i) & ~multi;
      act_ok_o = tmr_done[TMR_RC] &
                 ((st_q == BK_IDLE) | ((st_q == BK_PRECH) & tmr_done[TMR_RP]));
      act_acc  = act_i & ~multi & act_ok_o;
      rw_acc   = rw_any & (st_q == BK_OPEN);
      ap_acc   = rw_acc & ap_i;
      bad      = multi | (act_i & ~multi & ~act_ok_o) | (rw_any & (st_q != BK_OPEN));
      fire     = (st_q == BK_ARMED) & tmr_done[TMR_WAIT];
   end

   // timer loads
   always_comb begin
      tmr_ld[TMR_RAS]   = act_acc;
      tmr_val[TMR_RAS]  = less1(cfg_tras_i);
      tmr_ld[TMR_RC]    = act_acc;
      tmr_val[TMR_RC]   = less1(cfg_trc_i);
      tmr_ld[TMR_RP]    = fire;
      tmr_val[TMR_RP]   = less1(cfg_trp_i);
      tmr_ld[TMR_WAIT]  = ap_acc;
      tmr_val[TMR_WAIT] = dly - CW'(1);
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         BK_IDLE:  if (act_acc) st_d = BK_OPEN;
         BK_OPEN:  if (ap_acc)  st_d = BK_ARMED;
         BK_ARMED: if (fire)    st_d = BK_PRECH;
         BK_PRECH: begin
            if (act_acc)                st_d = BK_OPEN;
            else if (tmr_done[TMR_RP])  st_d = BK_IDLE;
         end
         default:  st_d = BK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= BK_IDLE;
         pre_q  <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pre_q  <= fire;
         viol_q <= bad;
      end
   end

   assign open_o      = (st_q == BK_OPEN) | (st_q == BK_ARMED);
   assign pre_start_o = pre_q;
   assign viol_o      = viol_q;

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      act_acc |=> (open_o && !act_ok_o));                                  // R2
   AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o |=> !pre_start_o);                                       // R4
   AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o |-> tmr_done[TMR_RAS]);                                  // R5
   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o |-> !open_o);                                            // R9
   AST_RP_HOLDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_start_o && cfg_trp_i > TW'(1)) |-> !act_ok_o);                  // R8
   AST_BAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && st_q != BK_ARMED) |=> $stable(open_o));                      // R10
   AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({act_i, rd_i, wr_i}) > 1) |=> viol_o);                   // R12
endmodule

// File: tb/bank_apre_tracker_tb_top.sv
module bank_apre_tracker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 6;

   typedef struct packed {
      logic       is_wr;
      logic       bl8;
      logic [7:0] req;
      logic [7:0] al, cl, twr, trtp, tras, trp, trc, gap, exp_d, exp_ok;
   } vec_t;

   // exp_d: edges from command to pulse; exp_ok: negedge index where act_ok rises
   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 8'd4, 8'd0, 8'd3, 8'd0, 8'd2, 8'd3,  8'd3, 8'd8,  8'd3, 8'd2,  8'd4},  // R4
      '{1'b0, 1'b1, 8'd6, 8'd1, 8'd3, 8'd0, 8'd4, 8'd4,  8'd2, 8'd10, 8'd2, 8'd7,  8'd8},  // R6
      '{1'b0, 1'b0, 8'd5, 8'd0, 8'd3, 8'd0, 8'd2, 8'd12, 8'd4, 8'd15, 8'd2, 8'd10, 8'd13}, // R5
      '{1'b1, 1'b0, 8'd7, 8'd0, 8'd3, 8'd3, 8'd2, 8'd3,  8'd3, 8'd6,  8'd3, 8'd7,  8'd9},  // R7
      '{1'b1, 1'b1, 8'd7, 8'd2, 8'd4, 8'd2, 8'd2, 8'd20, 8'd2, 8'd12, 8'd2, 8'd18, 8'd19}, // R7 with tRAS
      '{1'b0, 1'b1, 8'd4, 8'd0, 8'd3, 8'd0, 8'd2, 8'd3,  8'd1, 8'd30, 8'd5, 8'd4,  8'd24}  // R4, tRC wins
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic act_i = 0, rd_i = 0, wr_i = 0, ap_i = 0, cfg_bl8_i = 0;
   logic [TW-1:0] cfg_al_i = 0, cfg_cl_i = 3, cfg_twr_i = 0, cfg_trtp_i = 2;
   logic [TW-1:0] cfg_tras_i = 3, cfg_trp_i = 3, cfg_trc_i = 8;
   logic open_o, pre_start_o, act_ok_o, viol_o;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_apre_tracker #(.TW(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .act_i(act_i), .rd_i(rd_i), .wr_i(wr_i), .ap_i(ap_i),
      .cfg_bl8_i(cfg_bl8_i), .cfg_al_i(cfg_al_i), .cfg_cl_i(cfg_cl_i), .cfg_twr_i(cfg_twr_i),
      .cfg_trtp_i(cfg_trtp_i), .cfg_tras_i(cfg_tras_i), .cfg_trp_i(cfg_trp_i),
      .cfg_trc_i(cfg_trc_i), .open_o(open_o), .pre_start_o(pre_start_o),
      .act_ok_o(act_ok_o), .viol_o(viol_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; act_i = 0; rd_i = 0; wr_i = 0; ap_i = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_vec(input vec_t v);
      int got_d, got_ok;
      cfg_bl8_i = v.bl8; cfg_al_i = TW'(v.al); cfg_cl_i = TW'(v.cl); cfg_twr_i = TW'(v.twr);
      cfg_trtp_i = TW'(v.trtp); cfg_tras_i = TW'(v.tras); cfg_trp_i = TW'(v.trp);
      cfg_trc_i = TW'(v.trc);
      do_reset();
      act_i = 1; @(negedge clk); act_i = 0;
      chk(open_o == 1'b1 && act_ok_o == 1'b0, "R2 open after activate", int'(open_o), 1);
      repeat (int'(v.gap) - 1) @(negedge clk);
      rd_i = ~v.is_wr; wr_i = v.is_wr; ap_i = 1;
      @(negedge clk);
      rd_i = 0; wr_i = 0; ap_i = 0;
      got_d = -1; got_ok = -1;
      for (int j = 1; j <= 80; j++) begin
         @(negedge clk);
         if (j == int'(v.exp_d) - 1)
            chk(open_o == 1'b1, "R9 open before start", int'(open_o), 1);
         if (pre_start_o && got_d < 0) begin
            got_d = j;
            chk(open_o == 1'b0, "R9 closed at start", int'(open_o), 0);
         end
         if (act_ok_o && got_ok < 0) got_ok = j;
         if (got_d >= 0 && got_ok >= 0) break;
      end
      chk(got_d == int'(v.exp_d), $sformatf("R%0d precharge start", v.req), got_d, int'(v.exp_d));
      chk(got_ok == int'(v.exp_ok), "R8 activate allowed", got_ok, int'(v.exp_ok));
   endtask

   initial begin
      int pulses;
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R1: reset state
      cfg_bl8_i = 0; cfg_al_i = 0; cfg_cl_i = 3; cfg_twr_i = 0; cfg_trtp_i = 2;
      cfg_tras_i = 3; cfg_trp_i = 3; cfg_trc_i = 8;
      do_reset();
      @(negedge clk);
      chk(open_o == 0 && act_ok_o == 1 && pre_start_o == 0 && viol_o == 0,
          "R1 reset state", {open_o, act_ok_o, pre_start_o, viol_o}, 4'b0100);

      // R11: read on a closed bank
      rd_i = 1; @(negedge clk); rd_i = 0;
      chk(viol_o == 1 && open_o == 0, "R11 read while closed", {viol_o, open_o}, 2'b10);
      @(negedge clk);
      chk(viol_o == 0, "R11 flag clears", int'(viol_o), 0);

      // R12: two strobes together
      act_i = 1; rd_i = 1; @(negedge clk); act_i = 0; rd_i = 0;
      chk(viol_o == 1 && open_o == 0 && act_ok_o == 1, "R12 simultaneous strobes",
          {viol_o, open_o, act_ok_o}, 3'b101);

      // R2 then R10: second activate on an open bank
      act_i = 1; @(negedge clk);
      chk(open_o == 1 && viol_o == 0, "R2 activate accepted", {open_o, viol_o}, 2'b10);
      @(negedge clk); act_i = 0;
      chk(viol_o == 1 && open_o == 1, "R10 activate while open", {viol_o, open_o}, 2'b11);

      // R3: plain read and write keep the bank open
      rd_i = 1; @(negedge clk); rd_i = 0; wr_i = 1; @(negedge clk); wr_i = 0;
      pulses = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (pre_start_o || viol_o) pulses++;
      end
      chk(pulses == 0 && open_o == 1, "R3 no auto-precharge", pulses, 0);

      // R11 while armed: D = 2 here
      rd_i = 1; ap_i = 1; @(negedge clk); rd_i = 0; ap_i = 0;
      wr_i = 1; @(negedge clk); wr_i = 0;
      chk(viol_o == 1 && open_o == 1, "R11 write while armed", {viol_o, open_o}, 2'b11);
      @(negedge clk);
      chk(pre_start_o == 1, "R4 start after armed violation", int'(pre_start_o), 1);

      // R10 while precharging (tRP = 3 not elapsed)
      act_i = 1; @(negedge clk); act_i = 0;
      chk(viol_o == 1 && open_o == 0, "R10 activate during precharge", {viol_o, open_o}, 2'b10);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule